// File: doc/BRIEF.md
# Fractal Tile Transposing Loader

This block copies right-hand matrix operand tiles out of a staging buffer and into the operand buffer that feeds a multiply array. Each tile is a square fractal of 16 by 16 sixteen-bit elements, which is 512 bytes. In the staging buffer a tile is stored with the N0 axis innermost. In the operand buffer it must have the K0 reduction axis innermost, so that the array can fetch one full row of K0 values without striding. The block transposes every tile while it moves it, so no separate pass over memory is needed. The sequence of whole tiles is the same on both sides: k1 is the outer loop and n1 the inner loop.

A run starts with a one-cycle `start` pulse that carries the two outer tile counts. The block reads the source one element per cycle through a read port with one cycle of latency. It fills one bank of a two-bank tile store while it drains the other bank, in transposed order, through a write port. `done` pulses when the final element has been written.

Top module: `ftl_loader`

## Requirements
- R1: After reset, `done`, `src_rd_en` and `dst_wr_en` are all low.
- R2: A start with nonzero counts reads every source element of the T = k1_cnt*n1_cnt tiles exactly once, at consecutive ascending addresses from 0 to T*256-1. The source element at row r (K0 index) and column c (N0 index) of tile t = k1*n1_cnt + n1 sits at address t*256 + r*16 + c.
- R3: The element read from source address t*256 + r*16 + c is written to destination address t*256 + c*16 + r, so K0 is innermost in the destination.
- R4: The tile order is preserved. Destination writes go to consecutive ascending addresses from 0 to T*256-1, and tile t has base t*256 on both sides.
- R5: `done` is high for exactly one cycle per run, in the cycle that follows the cycle in which the final destination write is presented, and it is never high at any other time.
- R6: A `start` pulse while a run is in progress is ignored. This holds even if it carries different counts, including zero counts.
- R7: A start with k1_cnt or n1_cnt equal to zero raises `done` in the next cycle and performs no reads and no writes.
- R8: In a run of two or more tiles, a source read and a destination write take place in the same cycle at some point, because one bank fills while the other drains.
- R9: `src_rd_data` is taken in the cycle after the cycle in which `src_rd_en` was high.
- R10: `src_rd_en` is never high while no run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request that begins a run |
| k1_cnt | input | CNT_W | Number of tiles along K, sampled at start |
| n1_cnt | input | CNT_W | Number of tiles along N, sampled at start |
| done | output | 1 | One-cycle pulse when the run has completed |
| src_rd_en | output | 1 | Source read request |
| src_rd_addr | output | ADDR_W | Source element address |
| src_rd_data | input | 16 | Source data, valid one cycle after the request |
| dst_wr_en | output | 1 | Destination write strobe |
| dst_wr_addr | output | ADDR_W | Destination element address |
| dst_wr_data | output | 16 | Destination write data |

## Verification
Filling one bank from the source and draining the other bank to the destination can happen in the same cycle. A bank's release and the refill of that same bank also meet at a tile boundary. Runs of 2, 6 and 9 tiles force these overlaps. The bench judges them by replaying every destination element against an arithmetic source pattern, by checking that both address streams advance one step at a time, and by counting the cycles in which both ports were active. A stray start, with zero counts, is injected mid-run so that the busy and zero-count paths also collide.

// File: rtl/ftl_pkg.sv
package ftl_pkg;

    localparam int ELEM_W     = 16;
    localparam int TILE_DIM   = 16;
    localparam int TILE_ELEMS = TILE_DIM * TILE_DIM;
    localparam int IDX_W      = $clog2(TILE_ELEMS);
    localparam int HALF_W     = IDX_W / 2;
    localparam int BANKS      = 2;

    typedef logic [ELEM_W-1:0] elem_t;
    typedef logic [IDX_W-1:0]  idx_t;

    localparam idx_t IDX_LAST = idx_t'(TILE_ELEMS - 1);

    // one buffered write coming back from the source port
    typedef struct packed {
        logic valid;
        logic bank;
        idx_t idx;
    } fill_wr_t;

    // row/column swap of an in-tile offset: r*DIM+c -> c*DIM+r
    function automatic idx_t swap_idx(idx_t i);
        return {i[HALF_W-1:0], i[IDX_W-1:HALF_W]};
    endfunction

endpackage

// File: rtl/ftl_tilebuf.sv
module ftl_tilebuf
    import ftl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fill_wr_t         wr,
    input  elem_t            wr_data,
    input  logic             rd_bank,
    input  idx_t             rd_idx,
    output elem_t            rd_data,
    input  logic             rel,
    input  logic             rel_bank,
    output logic [BANKS-1:0] full
);

    logic [BANKS-1:0][ELEM_W-1:0] bank_rd;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        elem_t mem [TILE_ELEMS];

        always_ff @(posedge clk) begin
            if (wr.valid && wr.bank == 1'(b))
                mem[wr.idx] <= wr_data;
        end

        assign bank_rd[b] = mem[rd_idx];
    end

    assign rd_data = bank_rd[rd_bank];

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= '0;
        end else begin
            for (int b = 0; b < BANKS; b++) begin
                if (wr.valid && wr.bank == 1'(b) && wr.idx == IDX_LAST)
                    full[b] <= 1'b1;
                else if (rel && rel_bank == 1'(b))
                    full[b] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ftl_fill.sv
module ftl_fill
    import ftl_pkg::*;
#(
    parameter  int TILE_W = 16,
    localparam int ADDR_W = TILE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [TILE_W-1:0] tiles,
    input  logic [BANKS-1:0]  bank_full,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_rd_addr,
    output fill_wr_t          wr
);

    logic              active;
    logic [TILE_W-1:0] tiles_q;
    logic [TILE_W-1:0] tile;
    idx_t              idx;
    logic              bank;

    // source is walked in storage order; the target bank must be empty
    assign src_rd_en   = active & ~bank_full[bank];
    assign src_rd_addr = {tile, idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            tiles_q <= '0;
            tile    <= '0;
            idx     <= '0;
            bank    <= 1'b0;
            wr      <= '0;
        end else begin
            wr.valid <= src_rd_en;
            wr.bank  <= bank;
            wr.idx   <= idx;
            if (go) begin
                active  <= 1'b1;
                tiles_q <= tiles;
                tile    <= '0;
                idx     <= '0;
                bank    <= 1'b0;
            end else if (src_rd_en) begin
                idx <= idx + 1'b1;
                if (idx == IDX_LAST) begin
                    bank <= ~bank;
                    if (tile == tiles_q - 1'b1)
                        active <= 1'b0;
                    else
                        tile <= tile + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ftl_drain.sv
module ftl_drain
    import ftl_pkg::*;
#(
    parameter  int TILE_W = 16,
    localparam int ADDR_W = TILE_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [TILE_W-1:0] tiles,
    input  logic [BANKS-1:0]  bank_full,
    output logic              rd_bank,
    output idx_t              rd_idx,
    input  elem_t             rd_data,
    output logic              rel,
    output logic              rel_bank,
    output logic              dst_wr_en,
    output logic [ADDR_W-1:0] dst_wr_addr,
    output elem_t             dst_wr_data,
    output logic              dst_last
);

    logic              active;
    logic [TILE_W-1:0] tiles_q;
    logic [TILE_W-1:0] tile;
    idx_t              idx;
    logic              bank;
    logic              emit;
    logic              tile_end;

    // destination offset idx = c*DIM+r fetches stored element r*DIM+c
    assign emit     = active & bank_full[bank];
    assign tile_end = (idx == IDX_LAST);
    assign rd_bank  = bank;
    assign rd_idx   = swap_idx(idx);
    assign rel      = emit & tile_end;
    assign rel_bank = bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            tiles_q     <= '0;
            tile        <= '0;
            idx         <= '0;
            bank        <= 1'b0;
            dst_wr_en   <= 1'b0;
            dst_wr_addr <= '0;
            dst_wr_data <= '0;
            dst_last    <= 1'b0;
        end else begin
            dst_wr_en   <= emit;
            dst_wr_addr <= {tile, idx};
            dst_wr_data <= rd_data;
            dst_last    <= emit & tile_end & (tile == tiles_q - 1'b1);
            if (go) begin
                active  <= 1'b1;
                tiles_q <= tiles;
                tile    <= '0;
                idx     <= '0;
                bank    <= 1'b0;
            end else if (emit) begin
                idx <= idx + 1'b1;
                if (tile_end) begin
                    bank <= ~bank;
                    if (tile == tiles_q - 1'b1)
                        active <= 1'b0;
                    else
                        tile <= tile + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/ftl_loader.sv
module ftl_loader
    import ftl_pkg::*;
#(
    parameter  int CNT_W  = 8,
    localparam int TILE_W = 2 * CNT_W,
    localparam int ADDR_W = TILE_W + ftl_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  k1_cnt,
    input  logic [CNT_W-1:0]  n1_cnt,
    output logic              done,
    output logic              src_rd_en,
    output logic [ADDR_W-1:0] src_rd_addr,
    input  logic [ELEM_W-1:0] src_rd_data,
    output logic              dst_wr_en,
    output logic [ADDR_W-1:0] dst_wr_addr,
    output logic [ELEM_W-1:0] dst_wr_data
);

    logic              run;
    logic              accept;
    logic              go;
    logic [TILE_W-1:0] tiles_in;
    logic [BANKS-1:0]  full;
    fill_wr_t          wr;
    logic              rd_bank;
    idx_t              rd_idx;
    elem_t             rd_data;
    logic              rel;
    logic              rel_bank;
    logic              dst_last;
    logic              finish;

    // outer order k1-major, n1-minor gives linear tile index k1*n1_cnt+n1
    assign tiles_in = TILE_W'(k1_cnt) * TILE_W'(n1_cnt);
    assign accept   = start & ~run;
    assign go       = accept & (tiles_in != '0);
    assign finish   = dst_wr_en & dst_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= (accept && tiles_in == '0) || finish;
            if (go)
                run <= 1'b1;
            else if (finish)
                run <= 1'b0;
        end
    end

    ftl_fill #(.TILE_W(TILE_W)) u_fill (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .tiles      (tiles_in),
        .bank_full  (full),
        .src_rd_en  (src_rd_en),
        .src_rd_addr(src_rd_addr),
        .wr         (wr)
    );

    ftl_tilebuf u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .wr_data (src_rd_data),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .rel     (rel),
        .rel_bank(rel_bank),
        .full    (full)
    );

    ftl_drain #(.TILE_W(TILE_W)) u_drain (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .tiles      (tiles_in),
        .bank_full  (full),
        .rd_bank    (rd_bank),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .rel        (rel),
        .rel_bank   (rel_bank),
        .dst_wr_en  (dst_wr_en),
        .dst_wr_addr(dst_wr_addr),
        .dst_wr_data(dst_wr_data),
        .dst_last   (dst_last)
    );

endmodule

// File: rtl/ftl_loader_chk.sv
module ftl_loader_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [CNT_W-1:0]  k1_cnt,
    input logic [CNT_W-1:0]  n1_cnt,
    input logic              done,
    input logic              run,
    input logic              dst_last,
    input logic              src_rd_en,
    input logic [ADDR_W-1:0] src_rd_addr,
    input logic              dst_wr_en,
    input logic [ADDR_W-1:0] dst_wr_addr
);

    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        !run |-> !src_rd_en);  // R10

    AST_SRC_STEP: assert property (@(posedge clk) disable iff (rst)
        (src_rd_en && $past(src_rd_en)) |-> src_rd_addr == $past(src_rd_addr) + 1'b1);  // R2

    AST_DST_STEP: assert property (@(posedge clk) disable iff (rst)
        (dst_wr_en && $past(dst_wr_en)) |-> dst_wr_addr == $past(dst_wr_addr) + 1'b1);  // R4

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (dst_wr_en && dst_last) |=> done);  // R5

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> (!run && !dst_wr_en));  // R5

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (start && !run && (k1_cnt == '0 || n1_cnt == '0)) |=> (done && !src_rd_en));  // R7

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (start && run && !(dst_wr_en && dst_last)) |=> run);  // R6

endmodule

bind ftl_loader ftl_loader_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .k1_cnt     (k1_cnt),
    .n1_cnt     (n1_cnt),
    .done       (done),
    .run        (run),
    .dst_last   (dst_last),
    .src_rd_en  (src_rd_en),
    .src_rd_addr(src_rd_addr),
    .dst_wr_en  (dst_wr_en),
    .dst_wr_addr(dst_wr_addr)
);

// File: tb/tb_ftl_loader.sv
`timescale 1ns/1ps
module tb_ftl_loader;

    localparam int AW    = 24;
    localparam int MEMSZ = 9 * 256;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [7:0]    k1_cnt = '0;
    logic [7:0]    n1_cnt = '0;
    logic          done;
    logic          src_rd_en;
    logic [AW-1:0] src_rd_addr;
    logic [15:0]   src_rd_data = '0;
    logic          dst_wr_en;
    logic [AW-1:0] dst_wr_addr;
    logic [15:0]   dst_wr_data;

    always #2.5 clk = ~clk;

    ftl_loader dut (
        .clk(clk), .rst(rst), .start(start), .k1_cnt(k1_cnt), .n1_cnt(n1_cnt),
        .done(done), .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr),
        .src_rd_data(src_rd_data), .dst_wr_en(dst_wr_en),
        .dst_wr_addr(dst_wr_addr), .dst_wr_data(dst_wr_data)
    );

    function automatic logic [15:0] srcval(int a);
        return 16'(a * 40503 + (a >> 7) + 16'h1234);
    endfunction

    // source memory model with one cycle of read latency (R9)
    always @(posedge clk) begin
        if (src_rd_en) src_rd_data <= srcval(int'(src_rd_addr));
    end

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [15:0] dst_mem [MEMSZ];
    int  rd_cnt, wr_cnt, rd_order_err, wr_order_err, overlap, idle_rd;
    int  done_cnt, done_late, done_bad, exp_total;
    bit  in_run = 1'b0;
    bit  zero_mode = 1'b0;
    bit  last_prev = 1'b0;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog: actual %0d cycles, expected below %0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (last_prev && !done) done_late++;
            if (done && !last_prev && !zero_mode) done_bad++;
            if (done) done_cnt++;
            last_prev = dst_wr_en && (int'(dst_wr_addr) == exp_total - 1);
            if (src_rd_en) begin
                if (!in_run) idle_rd++;
                if (int'(src_rd_addr) != rd_cnt) rd_order_err++;
                rd_cnt++;
            end
            if (dst_wr_en) begin
                if (int'(dst_wr_addr) != wr_cnt) wr_order_err++;
                if (int'(dst_wr_addr) < MEMSZ) dst_mem[int'(dst_wr_addr)] = dst_wr_data;
                wr_cnt++;
            end
            if (src_rd_en && dst_wr_en) overlap++;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(int k1, int n1, bit poke);
        int bad;
        int c;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; rd_order_err = 0; wr_order_err = 0;
        overlap = 0; done_cnt = 0; done_late = 0; done_bad = 0;
        exp_total = k1 * n1 * 256;
        zero_mode = (exp_total == 0);
        for (int i = 0; i < MEMSZ; i++) dst_mem[i] = 16'h0;
        k1_cnt = 8'(k1);
        n1_cnt = 8'(n1);
        start  = 1'b1;
        in_run = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (zero_mode) begin
            chk(done == 1'b1, "R7", "done one cycle after zero-count start", int'(done), 1);
            repeat (4) @(negedge clk);
            in_run = 1'b0;
            chk(rd_cnt == 0 && wr_cnt == 0, "R7", "port activity on zero count",
                rd_cnt + wr_cnt, 0);
            chk(done_cnt == 1, "R7", "done pulses", done_cnt, 1);
        end else begin
            c = 0;
            while (!done && c < 20000) begin
                if (poke && c == 100) begin
                    start = 1'b1; k1_cnt = 8'd0; n1_cnt = 8'd5;
                end else begin
                    start = 1'b0;
                end
                @(negedge clk);
                c++;
            end
            start = 1'b0;
            repeat (4) @(negedge clk);
            in_run = 1'b0;
            chk(rd_cnt == exp_total, "R2", "source read count", rd_cnt, exp_total);
            chk(rd_order_err == 0, "R2", "source address order errors", rd_order_err, 0);
            chk(wr_cnt == exp_total, "R4", "destination write count", wr_cnt, exp_total);
            chk(wr_order_err == 0, "R4", "destination address order errors", wr_order_err, 0);
            bad = 0;
            for (int t = 0; t < k1 * n1; t++)
                for (int r = 0; r < 16; r++)
                    for (int cc = 0; cc < 16; cc++)
                        if (dst_mem[t*256 + cc*16 + r] !== srcval(t*256 + r*16 + cc)) bad++;
            chk(bad == 0, "R3", "transposed element mismatches (R9 latency)", bad, 0);
            chk(done_cnt == 1 && done_late == 0 && done_bad == 0, "R5",
                "done pulse count/timing", done_cnt*100 + done_late*10 + done_bad, 100);
            if (k1 * n1 >= 2)
                chk(overlap > 0, "R8", "cycles with read and write together", overlap, 1);
            if (poke)
                chk(done_cnt == 1 && rd_cnt == exp_total, "R6",
                    "busy start altered run (reads)", rd_cnt, exp_total);
        end
    endtask

    initial begin
        idle_rd = 0;
        exp_total = 0;
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && src_rd_en == 1'b0 && dst_wr_en == 1'b0, "R1",
            "outputs during reset", int'(done) + int'(src_rd_en) + int'(dst_wr_en), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0 && src_rd_en == 1'b0 && dst_wr_en == 1'b0, "R1",
            "outputs after reset", int'(done) + int'(src_rd_en) + int'(dst_wr_en), 0);
        run_case(1, 1, 1'b0);
        run_case(1, 2, 1'b0);
        run_case(0, 4, 1'b0);
        run_case(2, 1, 1'b0);
        run_case(2, 3, 1'b1);
        run_case(3, 0, 1'b0);
        run_case(3, 3, 1'b0);
        repeat (20) @(negedge clk);
        chk(idle_rd == 0, "R10", "source reads while idle", idle_rd, 0);
        summary();
        $finish;
    end

endmodule